// File: doc/BRIEF.md
# Serial Three-Wire Memory Slave

This block is the device end of a three-wire synchronous serial link (select, clock, data in, plus a data-out pin with its own enable) in front of a 64-word by 16-bit storage array. The array is a register file that stands in for nonvolatile storage. A host selects the device and clocks in an instruction. The instruction is a leading 1, a two-bit operation code and six address or sub-operation bits. The host then either clocks data out (read, or continuous read across addresses) or clocks data in (write, with page continuation inside an aligned group of eight words).

Programming operations are deferred. Write, erase, erase-all and write-all are staged in a local page buffer. They start only when the host drops the select line, and they run for a fixed number of system clocks. While the select line is high after that, the data-out pin reports readiness. The serial pins are oversampled by the faster system clock through synchronizers, so the serial clock is treated as data.

Top module: `sw3_mem_slave`

## Requirements
- R1: After reset the data-out enable is low, programming is disabled, and every word reads back as 16'hFFFF.
- R2: While select is high, data in is taken on each rising serial-clock edge. Zeros before the first 1 are skipped. That 1 is followed by the opcode (2 bits) and then six address bits, MSB first. Opcodes are: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 misc. For misc, address bits [5:4] select 2'b11 enable programming, 2'b00 disable programming, 2'b10 erase all, 2'b01 write all.
- R3: After the ninth rising edge of a read, the output is enabled and drives a 0. Each later rising edge puts out the next bit of the addressed word, MSB first.
- R4: If the serial clock keeps running, a read continues with the next address after each 16 data bits. Address 63 is followed by address 0, and no further dummy bit is sent.
- R5: Select low disables the output and clears any partly received instruction. A new read needs a full new instruction.
- R6: A write takes 16-bit words right after the address. Each further word goes to the next address in the same aligned 8-word group, so offset 7 is followed by offset 0. A word that is not complete when select falls is dropped.
- R7: A staged operation starts on the falling edge of select. The array changes exactly BUSY_CYCLES system clocks later.
- R8: After an operation has started, select high enables the output with 0 while busy and 1 when ready. This lasts until the next leading 1 is accepted.
- R9: Erase sets one word to 16'hFFFF. Erase all sets every word to 16'hFFFF. Write all sets every word to the one 16-bit word given.
- R10: While programming is disabled, write, erase, erase all and write all leave the array unchanged and start no busy period.
- R11: Serial activity while busy is ignored, so no instruction received in that time takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, 0 while disabled |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The bench builds the block with BUSY_CYCLES set to 200 and three system clocks per serial half period. With these values a whole write instruction fits inside one busy window, so the block's rejection of activity while busy can be shown. They also allow both readiness levels to be polled within one test. The default 6-bit address and 3-bit page width are kept, so the 63-to-0 wrap of continuous read and the offset-7-to-0 wrap of page writes are both reached with a few words each.

// File: rtl/sw3_pkg.sv
package sw3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } frame_st_e;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_PROG_OFF = 2'b00;
  localparam logic [1:0] SUB_FILL     = 2'b01;
  localparam logic [1:0] SUB_CLEAR    = 2'b10;
  localparam logic [1:0] SUB_PROG_ON  = 2'b11;
endpackage

// File: rtl/sw3_sync.sv
module sw3_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sw3_prog_timer.sv
module sw3_prog_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sw3_mem_array.sv
module sw3_mem_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [ADDR_W-1:0]                     raddr_i,
  output logic [DATA_W-1:0]                     rdata_o,
  input  logic                                  apply_i,
  input  logic                                  all_i,
  input  logic [ADDR_W-PAGE_W-1:0]              grp_i,
  input  logic [(1<<PAGE_W)-1:0]                mask_i,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]    data_i
);
  localparam int WORDS      = 1 << ADDR_W;
  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int GRP_W      = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int OFF = w % PAGE_WORDS;
    localparam logic [GRP_W-1:0] GRP = GRP_W'(w / PAGE_WORDS);
    logic [DATA_W-1:0] word_q;
    logic              hit;

    assign hit = apply_i && (all_i || (grp_i == GRP && mask_i[OFF]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '1;  // erased state
      else if (hit) word_q <= all_i ? data_i[0] : data_i[OFF];
    end

    assign words[w] = word_q;
  end

  assign rdata_o = words[raddr_i];
endmodule

// File: rtl/sw3_mem_slave.sv
module sw3_mem_slave
  import sw3_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int GRP_W      = ADDR_W - PAGE_W;
  localparam int CMD_BITS   = 2 + ADDR_W;
  localparam int CNT_W      = $clog2(DATA_W) + 1;

  logic cs_s, sk_s, di_s;
  logic cs_q, sk_q;
  logic sk_rise, cs_fall;
  logic busy, prog_done, prog_start;

  frame_st_e                             state_q;
  logic [CNT_W-1:0]                      cnt_q;
  logic [CMD_BITS-2:0]                   cmd_q;
  logic [ADDR_W-1:0]                     addr_q;
  logic [DATA_W-1:0]                     rd_sr_q;
  logic                                  do_bit_q;
  logic [DATA_W-2:0]                     wsr_q;
  logic                                  wen_q, pend_q, all_q, stat_q;
  logic [PAGE_WORDS-1:0]                 mask_q;
  logic [GRP_W-1:0]                      grp_q;
  logic [PAGE_WORDS-1:0][DATA_W-1:0]     buf_q;

  logic [CMD_BITS-1:0] frame;
  logic [1:0]          op;
  logic [ADDR_W-1:0]   fa;
  logic [1:0]          sub;
  logic [DATA_W-1:0]   word;
  logic [PAGE_W-1:0]   off;
  logic [ADDR_W-1:0]   rd_addr;
  logic [DATA_W-1:0]   rdata;
  logic                rd_act;

  sw3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sk_i, di_i}),
    .q_o   ({cs_s, sk_s, di_s})
  );

  assign sk_rise    = sk_s & ~sk_q & cs_s;
  assign cs_fall    = ~cs_s & cs_q;
  assign prog_start = cs_fall & pend_q & ~busy;

  sw3_prog_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(prog_start),
    .busy_o (busy),
    .done_o (prog_done)
  );

  assign frame   = {cmd_q, di_s};
  assign op      = frame[CMD_BITS-1 -: 2];
  assign fa      = frame[ADDR_W-1:0];
  assign sub     = fa[ADDR_W-1 -: 2];
  assign word    = {wsr_q, di_s};
  assign off     = addr_q[PAGE_W-1:0];
  assign rd_addr = (state_q == ST_CMD) ? fa : addr_q + 1'b1;
  assign rd_act  = (state_q == ST_READ);

  sw3_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(rd_addr),
    .rdata_o(rdata),
    .apply_i(prog_done),
    .all_i  (all_q),
    .grp_i  (grp_q),
    .mask_i (mask_q),
    .data_i (buf_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      rd_sr_q  <= '0;
      do_bit_q <= 1'b0;
      wsr_q    <= '0;
      wen_q    <= 1'b0;
      pend_q   <= 1'b0;
      all_q    <= 1'b0;
      stat_q   <= 1'b0;
      mask_q   <= '0;
      grp_q    <= '0;
      buf_q    <= '0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
      if (prog_start) begin
        pend_q <= 1'b0;
        stat_q <= 1'b1;
      end
      if (!cs_s) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (sk_rise && !busy) begin
        unique case (state_q)
          ST_IDLE: begin
            if (di_s) begin
              state_q <= ST_CMD;
              cnt_q   <= '0;
              stat_q  <= 1'b0;
              pend_q  <= 1'b0;
              all_q   <= 1'b0;
              mask_q  <= '0;
            end
          end
          ST_CMD: begin
            cmd_q <= frame[CMD_BITS-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_DONE;
              unique case (op)
                OP_READ: begin
                  state_q  <= ST_READ;
                  addr_q   <= fa;
                  rd_sr_q  <= rdata;
                  do_bit_q <= 1'b0;  // leading dummy bit
                end
                OP_WRITE: begin
                  if (wen_q) begin
                    state_q <= ST_WRITE;
                    addr_q  <= fa;
                    grp_q   <= fa[ADDR_W-1:PAGE_W];
                  end
                end
                OP_ERASE: begin
                  if (wen_q) begin
                    buf_q[fa[PAGE_W-1:0]]  <= '1;
                    mask_q[fa[PAGE_W-1:0]] <= 1'b1;
                    grp_q                  <= fa[ADDR_W-1:PAGE_W];
                    pend_q                 <= 1'b1;
                  end
                end
                default: begin
                  unique case (sub)
                    SUB_PROG_ON:  wen_q <= 1'b1;
                    SUB_PROG_OFF: wen_q <= 1'b0;
                    SUB_CLEAR: begin
                      if (wen_q) begin
                        all_q    <= 1'b1;
                        buf_q[0] <= '1;
                        pend_q   <= 1'b1;
                      end
                    end
                    default: begin
                      if (wen_q) begin
                        all_q   <= 1'b1;
                        addr_q  <= '0;
                        state_q <= ST_WRITE;
                      end
                    end
                  endcase
                end
              endcase
            end
          end
          ST_READ: begin
            do_bit_q <= rd_sr_q[DATA_W-1];
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_q   <= '0;
              addr_q  <= addr_q + 1'b1;
              rd_sr_q <= rdata;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              rd_sr_q <= {rd_sr_q[DATA_W-2:0], 1'b0};
            end
          end
          ST_WRITE: begin
            wsr_q <= word[DATA_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_q       <= '0;
              buf_q[off]  <= word;
              mask_q[off] <= 1'b1;
              pend_q      <= 1'b1;
              if (all_q) state_q <= ST_DONE;
              else       addr_q  <= {addr_q[ADDR_W-1:PAGE_W], off + 1'b1};  // wrap inside group
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign do_oe_o = cs_q & (rd_act | (state_q == ST_IDLE & stat_q));
  assign do_o    = do_oe_o & (rd_act ? do_bit_q : ~busy);
endmodule

// File: rtl/sw3_mem_slave_chk.sv
module sw3_mem_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_q,
  input logic busy,
  input logic wen_q,
  input logic rd_act,
  input logic cs_fall,
  input logic do_o,
  input logic do_oe_o
);
  p_hiz_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |-> !do_oe_o);

  p_dummy_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_act) |-> (do_oe_o && !do_o));

  p_start_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cs_fall));

  p_prog_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wen_q);

  p_status_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && busy) |-> !do_o);

  p_no_read_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !rd_act);
endmodule

bind sw3_mem_slave sw3_mem_slave_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_q   (cs_q),
  .busy   (busy),
  .wen_q  (wen_q),
  .rd_act (rd_act),
  .cs_fall(cs_fall),
  .do_o   (do_o),
  .do_oe_o(do_oe_o)
);

// File: tb/sw3_mem_slave_tb.sv
module sw3_mem_slave_tb;
  localparam int BUSY = 200;
  localparam int H    = 3;
  localparam int S_IDLE = 0, S_CMD = 1, S_RD = 2, S_WR = 3, S_DONE = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, oe_w;
  always #5 clk = ~clk;

  sw3_mem_slave #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  int checks = 0, errors = 0;
  string req = "R1";
  bit finished = 0;

  // behavioural model
  int mem [64];
  int m_st = S_IDLE, m_n = 0, m_cmd = 0, m_addr = 0, m_bit = 0;
  int m_base = 0, m_off = 0, m_wacc = 0, m_wn = 0, m_alld = 0, m_busy = 0;
  bit m_wen = 0, m_pend = 0, m_all = 0, m_stat = 0, p_cs = 0, p_sk = 0;
  int q_addr[$], q_data[$];
  bit e_oe [3], e_do [3];

  task automatic apply_pending();
    if (m_all) for (int i = 0; i < 64; i++) mem[i] = m_alld;
    foreach (q_addr[i]) mem[q_addr[i]] = q_data[i];
  endtask

  task automatic decode();
    int op, a;
    op = (m_cmd >> 6) & 3;
    a  = m_cmd & 63;
    m_st = S_DONE;
    case (op)
      2: begin m_st = S_RD; m_addr = a; m_bit = -1; end
      1: if (m_wen) begin m_st = S_WR; m_base = a & 56; m_off = a & 7; m_wn = 0; m_wacc = 0; end
      3: if (m_wen) begin m_pend = 1; q_addr.push_back(a); q_data.push_back(16'hFFFF); end
      default: case (a >> 4)
        3: m_wen = 1;
        0: m_wen = 0;
        2: if (m_wen) begin m_pend = 1; m_all = 1; m_alld = 16'hFFFF; end
        default: if (m_wen) begin m_all = 1; m_st = S_WR; m_wn = 0; m_wacc = 0; end
      endcase
    endcase
  endtask

  task automatic model_step(output bit n_oe, output bit n_do);
    bit rise, fall, was_busy;
    rise = cs && sk && !p_sk;
    fall = !cs && p_cs;
    was_busy = (m_busy > 0);
    if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) apply_pending();
    end
    if (!cs) begin
      if (fall && m_pend && !was_busy) begin m_busy = BUSY; m_stat = 1; m_pend = 0; end
      m_st = S_IDLE;
    end else if (rise && !was_busy) begin
      case (m_st)
        S_IDLE: if (di) begin
          m_st = S_CMD; m_n = 0; m_cmd = 0; m_stat = 0; m_pend = 0; m_all = 0;
          q_addr.delete(); q_data.delete();
        end
        S_CMD: begin
          m_cmd = (m_cmd << 1) | di; m_n++;
          if (m_n == 8) decode();
        end
        S_RD: begin
          m_bit++;
          if (m_bit == 16) begin m_addr = (m_addr + 1) % 64; m_bit = 0; end
        end
        S_WR: begin
          m_wacc = ((m_wacc << 1) | di) & 16'hFFFF; m_wn++;
          if (m_wn == 16) begin
            m_wn = 0; m_pend = 1;
            if (m_all) begin m_alld = m_wacc; m_st = S_DONE; end
            else begin
              q_addr.push_back(m_base + m_off); q_data.push_back(m_wacc);
              m_off = (m_off + 1) % 8;
            end
          end
        end
        default: ;
      endcase
    end
    p_cs = cs; p_sk = sk;
    n_oe = cs && (m_st == S_RD || (m_st == S_IDLE && m_stat));
    if (!n_oe)             n_do = 0;
    else if (m_st == S_RD) n_do = (m_bit < 0) ? 1'b0 : 1'(mem[m_addr] >> (15 - m_bit));
    else                   n_do = (m_busy == 0);
  endtask

  task automatic tick(input bit c, input bit s, input bit d);
    bit n_oe, n_do;
    @(negedge clk);
    checks++;
    if (oe_w !== e_oe[2] || do_w !== e_do[2]) begin
      errors++;
      $display("FAIL %s: oe/do actual %b/%b expected %b/%b at %0t", req, oe_w, do_w, e_oe[2], e_do[2], $time);
    end
    cs = c; sk = s; di = d;
    model_step(n_oe, n_do);
    e_oe[2] = e_oe[1]; e_oe[1] = e_oe[0]; e_oe[0] = n_oe;
    e_do[2] = e_do[1]; e_do[1] = e_do[0]; e_do[0] = n_do;
  endtask

  task automatic clk_bit(input bit d);
    repeat (H) tick(1, 0, d);
    repeat (H) tick(1, 1, d);
  endtask

  task automatic send(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(1'((v >> i) & 1));
  endtask

  task automatic instr(input int op, input int a);
    clk_bit(1);
    send(op, 2);
    send(a, 6);
  endtask

  task automatic desel(input int n);
    repeat (n) tick(0, 0, 0);
  endtask

  task automatic read_run(input int a, input int words);
    instr(2, a);
    for (int i = 0; i < 16 * words; i++) clk_bit(0);
    desel(6);
  endtask

  task automatic wait_ready();
    desel(BUSY + 10);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin e_oe[i] = 0; e_do[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; desel(8); read_run(5, 2);
    // R10: programming disabled at power-up
    req = "R10"; instr(1, 3); send(16'h1234, 16); desel(6);
    repeat (6) tick(1, 0, 0);
    desel(6); read_run(3, 1);
    // R2: enable programming, leading zeros skipped
    req = "R2"; clk_bit(0); clk_bit(0); instr(0, 6'h30); desel(6);
    // R6/R7/R8: single write, poll busy then ready
    req = "R7"; instr(1, 3); send(16'h1234, 16); desel(4);
    req = "R8"; repeat (12) tick(1, 0, 0); desel(4);
    wait_ready(); repeat (8) tick(1, 0, 0);
    req = "R3"; instr(2, 3); for (int i = 0; i < 16; i++) clk_bit(0); desel(6);
    // R6: page write wraps inside its group, partial word dropped
    req = "R6"; instr(1, 13); send(16'hA001, 16); send(16'hA002, 16); send(16'hA003, 16);
    send(16'hA004, 16); send(5'h1B, 5); desel(4); wait_ready();
    read_run(8, 8);
    instr(1, 62); send(16'h6262, 16); send(16'h6363, 16); send(16'h3838, 16); desel(4); wait_ready();
    instr(1, 0); send(16'h0F0F, 16); desel(4); wait_ready();
    // R4: continuous read across 63 -> 0
    req = "R4"; read_run(62, 3);
    // R5: abort a read mid-word, then issue a fresh one
    req = "R5"; instr(2, 13); send(0, 7); desel(6); clk_bit(0); clk_bit(1); clk_bit(0); desel(6);
    read_run(14, 1);
    // R11: instruction while busy has no effect
    req = "R11"; instr(1, 20); send(16'h1111, 16); desel(4);
    instr(1, 21); send(16'h2222, 16); desel(4); wait_ready();
    read_run(20, 2);
    // R9: erase, write all, erase all
    req = "R9"; instr(3, 3); desel(4); wait_ready(); read_run(2, 2);
    instr(0, 6'h10); send(16'hA5C3, 16); desel(4); wait_ready(); read_run(40, 2);
    instr(0, 6'h20); desel(4); wait_ready(); read_run(0, 2);
    // R10: disable, then write / erase all / write all ignored
    req = "R10"; instr(0, 6'h00); desel(6);
    instr(1, 9); send(16'h5555, 16); desel(6); repeat (6) tick(1, 0, 0); desel(6);
    instr(0, 6'h10); send(16'h0000, 16); desel(6);
    read_run(9, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL %s: watchdog actual running expected finished", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule